// File: doc/BRIEF.md
# Cache Valid-Bit Purge Controller

This block holds the valid bits and address tags of a four-way, 64-set cache with 16-byte lines and offers two ways of invalidating them. A control-register write carries a cache-enable bit and a flush bit. The flush bit wipes every valid bit in a single clock and pulses a clear to the neighbouring replacement-order (LRU) logic. The CPU address port serves normal lookups, reporting hit and way. It also recognises an aliased address window: an access whose top three address bits read `010` names a line by the rest of its address, and that one line is invalidated if present.

An aliased purge runs over two cycles. In the first, the tags of all four ways in the selected set are compared and the matching way is latched. In the second, that way's valid bit is cleared. A busy output stalls the requester for both cycles. A refill path writes tag and valid bit for one way. Data storage and the refill policy live elsewhere.

Top module: `valid_purge_ctl`

## Requirements
- R1: While reset is asserted and right after it, `cache_on`, `busy`, `purge_err` and `lru_clr` are 0, and all valid bits are cleared.
- R2: A control write with `cfg_flush`=1 raises `lru_clr` in that same cycle and clears every valid bit at the closing clock edge.
- R3: A control write loads `cfg_enable` into `cache_on`. A lookup reports a hit only while `cache_on` is 1. A write with `cfg_flush`=0 leaves the valid bits unchanged.
- R4: A lookup takes the set index from address bits [9:4] and compares bits [28:10] against the stored tag. Bits [31:29] are ignored (any value except `010`). On a hit, `cpu_hit_way` gives the way number, 0 to 3.
- R5: A request with address bits [31:29]=`010` and `cpu_size`=`10` (longword) while not busy is an associative purge. It clears only the valid bit of the way whose tag matches address bits [28:10] in set [9:4].
- R6: `busy` is 1 in the accepting cycle and in the following cycle, then 0. The cleared line misses from the cycle after that.
- R7: A purge-window request made while `busy` is 1 from an earlier purge is ignored. Its line stays valid.
- R8: A purge whose address matches no way takes the same two busy cycles and changes no valid bit.
- R9: A purge-window request with `cpu_size` other than `10` (`00` byte, `01` word, `11`) raises `purge_err` in that cycle, does not raise `busy`, and changes no valid bit.
- R10: A flush write in the clear cycle of a purge leaves every line invalid. The purge still ends with `busy` falling on schedule.
- R11: Sixteen successive purges at a 16-byte stride invalidate a 256-byte region. The next line above it stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_enable | input | 1 | Cache-enable bit of the written value |
| cfg_flush | input | 1 | Flush-all bit of the written value |
| cpu_req | input | 1 | CPU access valid |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| fill_we | input | 1 | Refill write: set tag and valid bit |
| fill_way | input | 2 | Way written by the refill |
| fill_idx | input | 6 | Set written by the refill |
| fill_tag | input | 19 | Tag written by the refill |
| cache_on | output | 1 | Cache enabled |
| cpu_hit | output | 1 | Lookup hit (outside the purge window) |
| cpu_hit_way | output | 2 | Way that hit |
| busy | output | 1 | Associative purge in progress |
| purge_err | output | 1 | Purge-window access of wrong size |
| lru_clr | output | 1 | Clear-all pulse to the LRU logic |

## Verification
The collision of interest is a global flush landing in the clear cycle of an associative purge: both update the valid array at the same clock edge. The bench starts a purge, issues the flush write in the purge's second busy cycle, and checks that `lru_clr` and `busy` are high together. It then checks that `busy` falls one cycle later and that every previously filled line misses. A refill in the same cycle as a flush is covered the same way, with the flush taking precedence. A second purge is issued afterwards to confirm the sequencer returned to idle.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam logic [1:0] SZ_LONG = 2'b10;

  typedef enum logic {
    PS_IDLE,
    PS_CLEAR
  } purge_st_e;
endpackage

// File: rtl/vpc_rst_sync.sv
module vpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/vpc_tag_array.sv
module vpc_tag_array #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 19,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_we,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic [WAYS-1:0]  look_match,
  input  logic             clr_we,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [WAYS-1:0]  clr_mask,
  input  logic             flush
);
  logic [SETS-1:0][WAYS-1:0] vld_q, vld_d;

  // next state: refill sets, purge clears, flush overrides both
  always_comb begin
    vld_d = vld_q;
    if (fill_we) vld_d[fill_idx][fill_way] = 1'b1;
    if (clr_we)  vld_d[clr_idx] = vld_d[clr_idx] & ~clr_mask;
    if (flush)   vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             tag_wen;

    assign tag_wen = fill_we && (fill_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (tag_wen) tag_mem[fill_idx] <= fill_tag;
    end

    assign look_match[w] = vld_q[look_idx][w] && (tag_mem[look_idx] == look_tag);
  end

  // R2
  flush_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R5
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((vld_q[$past(clr_idx)] & $past(clr_mask)) == '0));
endmodule

// File: rtl/vpc_purge_seq.sv
module vpc_purge_seq
  import vpc_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic             cfg_flush,
  input  logic             win_req,
  input  logic [1:0]       win_size,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [WAYS-1:0]  win_match,
  output logic             cache_on,
  output logic             busy,
  output logic             purge_err,
  output logic             clr_we,
  output logic [IDX_W-1:0] clr_idx,
  output logic [WAYS-1:0]  clr_mask,
  output logic             flush
);
  purge_st_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WAYS-1:0]  mask_q, mask_d;
  logic             on_q, on_d;
  logic             idle, accept;

  assign idle      = (st_q == PS_IDLE);
  assign accept    = win_req && (win_size == SZ_LONG) && idle;
  assign purge_err = win_req && (win_size != SZ_LONG) && idle;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    mask_d = mask_q;
    on_d   = on_q;
    unique case (st_q)
      PS_IDLE:  if (accept) st_d = PS_CLEAR;
      PS_CLEAR: st_d = PS_IDLE;
      default:  st_d = PS_IDLE;
    endcase
    if (accept) begin
      idx_d  = win_idx;
      mask_d = win_match;
    end
    if (cfg_we) on_d = cfg_enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      idx_q  <= '0;
      mask_q <= '0;
      on_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      mask_q <= mask_d;
      on_q   <= on_d;
    end
  end

  assign busy     = accept || (st_q == PS_CLEAR);
  assign clr_we   = (st_q == PS_CLEAR);
  assign clr_idx  = idx_q;
  assign clr_mask = mask_q;
  assign flush    = cfg_we && cfg_flush;
  assign cache_on = on_q;

  // R6
  accept_to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st_q == PS_CLEAR));

  // R6
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_CLEAR) |=> (st_q == PS_IDLE));

  // R9
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_err |=> (st_q == PS_IDLE));
endmodule

// File: rtl/valid_purge_ctl.sv
module valid_purge_ctl #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SETS     = 64,
  parameter int unsigned LINE_B   = 16,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned REGION_W = 3,
  parameter logic [2:0]  WIN_CODE = 3'b010,
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned OFF_W   = $clog2(LINE_B),
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned TAG_W   = ADDR_W - REGION_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_enable,
  input  logic              cfg_flush,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              fill_we,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  output logic              cache_on,
  output logic              cpu_hit,
  output logic [WAY_W-1:0]  cpu_hit_way,
  output logic              busy,
  output logic              purge_err,
  output logic              lru_clr
);
  logic              rst_n_s;
  logic              in_win, win_req, clr_we, flush;
  logic [IDX_W-1:0]  cpu_idx, clr_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic [WAYS-1:0]   match, clr_mask, hit_vec;
  logic              unused_offset;

  assign in_win  = (cpu_addr[ADDR_W-1 -: REGION_W] == WIN_CODE[REGION_W-1:0]);
  assign win_req = cpu_req && in_win;
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[OFF_W + IDX_W +: TAG_W];
  assign unused_offset = ^cpu_addr[OFF_W-1:0];

  vpc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  vpc_tag_array #(
    .WAYS (WAYS), .SETS (SETS), .IDX_W (IDX_W), .TAG_W (TAG_W), .WAY_W (WAY_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .fill_we    (fill_we),
    .fill_way   (fill_way),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .look_idx   (cpu_idx),
    .look_tag   (cpu_tag),
    .look_match (match),
    .clr_we     (clr_we),
    .clr_idx    (clr_idx),
    .clr_mask   (clr_mask),
    .flush      (flush)
  );

  vpc_purge_seq #(
    .WAYS (WAYS), .IDX_W (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_we     (cfg_we),
    .cfg_enable (cfg_enable),
    .cfg_flush  (cfg_flush),
    .win_req    (win_req),
    .win_size   (cpu_size),
    .win_idx    (cpu_idx),
    .win_match  (match),
    .cache_on   (cache_on),
    .busy       (busy),
    .purge_err  (purge_err),
    .clr_we     (clr_we),
    .clr_idx    (clr_idx),
    .clr_mask   (clr_mask),
    .flush      (flush)
  );

  assign hit_vec = match & {WAYS{cpu_req && cache_on && !in_win}};
  assign cpu_hit = |hit_vec;
  assign lru_clr = flush;

  always_comb begin
    cpu_hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) cpu_hit_way = WAY_W'(w);
    end
  end
endmodule

// File: tb/test_valid_purge_ctl.sv
`timescale 1ns/1ps
module test_valid_purge_ctl;
  localparam logic [31:0] WIN = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_enable, cfg_flush;
  logic        cpu_req;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic        fill_we;
  logic [1:0]  fill_way;
  logic [5:0]  fill_idx;
  logic [18:0] fill_tag;
  logic        cache_on, cpu_hit, busy, purge_err, lru_clr;
  logic [1:0]  cpu_hit_way;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    logic       hit;
    logic [1:0] way;
    string      r;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  valid_purge_ctl i_valid_purge_ctl (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_enable (cfg_enable), .cfg_flush (cfg_flush),
    .cpu_req (cpu_req), .cpu_addr (cpu_addr), .cpu_size (cpu_size),
    .fill_we (fill_we), .fill_way (fill_way), .fill_idx (fill_idx), .fill_tag (fill_tag),
    .cache_on (cache_on), .cpu_hit (cpu_hit), .cpu_hit_way (cpu_hit_way),
    .busy (busy), .purge_err (purge_err), .lru_clr (lru_clr)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [18:0] tag, logic [5:0] idx);
    return {3'b000, tag, idx, 4'h0};
  endfunction

  // monitor: pops expected lookups and compares them with the design's result
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1;
      if (cpu_req && cpu_addr[31:29] != 3'b010 && sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.r, 32'(cpu_hit), 32'(e.hit));
        if (e.hit) chk(e.r, 32'(cpu_hit_way), 32'(e.way));
      end
    end
  end

  task automatic probe(logic [31:0] a, logic h, logic [1:0] w, string r);
    exp_t e;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_size = 2'b10;
    e.hit = h; e.way = w; e.r = r;
    sb.push_back(e);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic fill(logic [1:0] w, logic [18:0] tag, logic [5:0] idx);
    @(negedge clk);
    fill_we = 1'b1; fill_way = w; fill_idx = idx; fill_tag = tag;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic cfg(logic en, logic fl, string r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_enable = en; cfg_flush = fl;
    #1 chk(r, 32'(lru_clr), 32'(fl));
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic purge(logic [31:0] a, bit poke, logic [31:0] a2, string r);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a | WIN; cpu_size = 2'b10;
    #1 chk(r, 32'(busy), 1);
    @(negedge clk);
    if (poke) cpu_addr = a2 | WIN;
    else      cpu_req = 1'b0;
    #1 chk(r, 32'(busy), 1);
    @(negedge clk);
    cpu_req = 1'b0;
    #1 chk(r, 32'(busy), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  localparam logic [18:0] TA = 19'h01234, TB = 19'h00ABC, TC = 19'h7FFFF;
  localparam logic [18:0] TD = 19'h00001, TE = 19'h02222, TF = 19'h03333;

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_enable = 0; cfg_flush = 0;
    cpu_req = 0; cpu_addr = '0; cpu_size = 2'b10;
    fill_we = 0; fill_way = '0; fill_idx = '0; fill_tag = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cache_on", 32'(cache_on), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 purge_err", 32'(purge_err), 0);
    chk("R1 lru_clr", 32'(lru_clr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1 cache_on after release", 32'(cache_on), 0);

    // R1: enable without flush, nothing valid after reset
    cfg(1'b1, 1'b0, "R3 no lru_clr");
    probe(mk(TA, 5), 1'b0, 2'd0, "R1 empty after reset");

    // R2 flush with enable
    cfg(1'b1, 1'b1, "R2 lru_clr pulse");
    #1 chk("R3 cache_on", 32'(cache_on), 1);

    fill(2'd0, TA, 6'd5);
    fill(2'd1, TB, 6'd5);
    fill(2'd3, TC, 6'd5);
    fill(2'd2, TA, 6'd6);

    // R4 lookups
    probe(mk(TA, 5), 1'b1, 2'd0, "R4 way0");
    probe(mk(TB, 5), 1'b1, 2'd1, "R4 way1");
    probe(mk(TC, 5), 1'b1, 2'd3, "R4 way3");
    probe(mk(TA, 6), 1'b1, 2'd2, "R4 way2 other set");
    probe(mk(TD, 5), 1'b0, 2'd0, "R4 tag miss");
    probe(mk(TA, 7), 1'b0, 2'd0, "R4 set miss");
    probe(mk(TA, 5) | 32'h2000_0000, 1'b1, 2'd0, "R4 region masked");
    probe(mk(TA, 5) | 32'hE000_000C, 1'b1, 2'd0, "R4 region and offset masked");

    // R3 enable gating, valid bits kept
    cfg(1'b0, 1'b0, "R3 disable no lru_clr");
    #1 chk("R3 cache_on off", 32'(cache_on), 0);
    probe(mk(TA, 5), 1'b0, 2'd0, "R3 no hit when disabled");
    cfg(1'b1, 1'b0, "R3 enable no lru_clr");
    probe(mk(TA, 5), 1'b1, 2'd0, "R3 valid kept across enable writes");

    // R5 and R7: purge B; a window request during clear cycle targets C
    purge(mk(TB, 5), 1'b1, mk(TC, 5), "R6 busy sequence");
    probe(mk(TB, 5), 1'b0, 2'd0, "R5 purged line misses");
    probe(mk(TA, 5), 1'b1, 2'd0, "R5 neighbour way kept");
    probe(mk(TC, 5), 1'b1, 2'd3, "R7 request during busy ignored");
    probe(mk(TA, 6), 1'b1, 2'd2, "R5 other set kept");

    // R8 no-match purge
    purge(mk(TD, 5), 1'b0, '0, "R8 busy two cycles");
    probe(mk(TA, 5), 1'b1, 2'd0, "R8 no change way0");
    probe(mk(TC, 5), 1'b1, 2'd3, "R8 no change way3");

    // R9 wrong sizes
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = mk(TA, 5) | WIN; cpu_size = 2'(s);
        #1;
        chk("R9 purge_err", 32'(purge_err), 1);
        chk("R9 no busy", 32'(busy), 0);
        @(negedge clk);
        cpu_req = 1'b0; cpu_size = 2'b10;
        #1 chk("R9 no busy after", 32'(busy), 0);
      end
    end
    probe(mk(TA, 5), 1'b1, 2'd0, "R9 line kept");

    // R11 256-byte region
    for (int k = 0; k < 17; k++) fill(2'd0, TE, 6'(16 + k));
    for (int k = 0; k < 16; k++) purge(mk(TE, 16) + 32'(16 * k), 1'b0, '0, "R11 busy");
    for (int k = 0; k < 16; k++) probe(mk(TE, 6'(16 + k)), 1'b0, 2'd0, "R11 region purged");
    probe(mk(TE, 32), 1'b1, 2'd0, "R11 next line kept");

    // R10 flush in the clear cycle of a purge
    fill(2'd1, TF, 6'd40);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = mk(TA, 6) | WIN; cpu_size = 2'b10;
    #1 chk("R10 busy accept", 32'(busy), 1);
    @(negedge clk);
    cpu_req = 1'b0;
    cfg_we = 1'b1; cfg_enable = 1'b1; cfg_flush = 1'b1;
    #1;
    chk("R10 lru_clr", 32'(lru_clr), 1);
    chk("R10 busy clear", 32'(busy), 1);
    @(negedge clk);
    cfg_we = 1'b0; cfg_flush = 1'b0;
    #1 chk("R10 busy falls", 32'(busy), 0);
    probe(mk(TA, 5), 1'b0, 2'd0, "R10 A flushed");
    probe(mk(TC, 5), 1'b0, 2'd0, "R10 C flushed");
    probe(mk(TE, 32), 1'b0, 2'd0, "R10 E flushed");
    probe(mk(TF, 40), 1'b0, 2'd0, "R10 F flushed");
    purge(mk(TF, 40), 1'b0, '0, "R10 next purge accepted");

    // R2 flush racing a refill: flush wins
    @(negedge clk);
    fill_we = 1'b1; fill_way = 2'd2; fill_idx = 6'd9; fill_tag = TD;
    cfg_we = 1'b1; cfg_enable = 1'b1; cfg_flush = 1'b1;
    @(negedge clk);
    fill_we = 1'b0; cfg_we = 1'b0; cfg_flush = 1'b0;
    probe(mk(TD, 9), 1'b0, 2'd0, "R2 flush beats refill");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL R4 scoreboard actual=%0d expected=0", sb.size());
    end
    finish_up();
  end
endmodule